// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger Levels

This block holds the receive and transmit byte queues of a 16550-class serial port. Received bytes arrive from the line deserializer one per strobe. The host reaches the block through single-cycle data-register reads and writes and through a write-only control byte. From these the block keeps the data-ready, overrun and transmit-holding-empty status bits. It also produces one-cycle pulses that set the receive and transmit interrupt sources in the port's interrupt logic.

With queueing switched off, the block behaves like the older single-buffer part. One holding byte serves the receive side, and a host write goes straight to the serializer. With queueing switched on, each direction gets a 14-byte queue. The receive source fires when the stored count reaches a chosen depth of 1, 4, 8 or 14 bytes. The transmit source fires only once the transmit queue has fully drained.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Reset leaves queueing off, both queues and the holding byte empty, trigger code 0, `data_ready`=0, `overrun`=0, `thr_empty`=1, `host_rdata`=0 and no pulses. After reset, receive behaves in single-buffer mode.
- R2: A `ctl_we` write decodes its byte as follows. Bit 0 turns queueing on (1) or off (0). Bit 1 empties the receive queue and bit 2 empties the transmit queue; these act in that write only and are not stored. Any write that changes bit 0 empties both queues and the holding byte. A clear wins over receive, read, write and drain activity in the same cycle.
- R3: Single-buffer receive: an `rx_valid` byte goes into the holding byte. From the next edge on, `data_ready`=1, and `rx_irq_set` pulses for one cycle per byte. A `host_rd` returns that byte on `host_rdata` and clears `data_ready`, both at the next edge.
- R4: Single-buffer overrun: a byte that arrives while the holding byte is still unread, with no read in the same cycle, replaces it and sets `overrun`.
- R5: Single-buffer transmit: a `host_wr` byte appears on `tx_data` with `tx_valid`=1 one cycle later. `tx_irq_set` pulses and `thr_empty` stays 1, whatever `tx_ready` is.
- R6: Queued receive returns bytes in arrival order, up to 14 held. `data_ready` stays 1 while any byte is held.
- R7: Control bits 7:6 select a trigger depth: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14. In queued mode, `rx_irq_set` pulses once, in the cycle after the push that brings the held count to that depth.
- R8: In queued mode, a byte that arrives with 14 bytes held is dropped and sets `overrun`.
- R9: A queued read with nothing held leaves `host_rdata` unchanged.
- R10: `ovr_clr` clears `overrun` at the next edge. A new overrun in the same cycle wins.
- R11: In queued mode, host writes enter the transmit queue and are dropped when 14 are held. `thr_empty` falls at the edge after a write. While `tx_ready`=1, one byte per cycle leaves in order, on `tx_data` with `tx_valid`=1, one cycle after the edge that takes it.
- R12: When the last queued transmit byte leaves, `thr_empty` returns to 1 and `tx_irq_set` pulses once, both in the following cycle. Emptying the transmit queue by a control write sets `thr_empty` without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: enable, clears, trigger code |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | DATA_W | Deserialized byte |
| host_wr | input | 1 | Host write to the data register |
| host_wdata | input | DATA_W | Host write byte |
| host_rd | input | 1 | Host read of the data register |
| host_rdata | output | DATA_W | Byte returned by the last read |
| ovr_clr | input | 1 | Clears the overrun bit |
| tx_ready | input | 1 | Serializer can take a queued byte |
| tx_valid | output | 1 | Byte handed to the serializer this cycle |
| tx_data | output | DATA_W | Byte for the serializer |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | Received byte lost |
| thr_empty | output | 1 | Transmit holding side empty |
| rx_irq_set | output | 1 | Pulse setting the receive interrupt source |
| tx_irq_set | output | 1 | Pulse setting the transmit interrupt source |

## Verification
Every output is a register. A receive strobe, host read, host write, control write or drain cycle therefore shows its effect on the ports exactly one rising edge after the edge that samples it. This covers the trigger pulse on the push that reaches the depth and the drain pulse on the edge that takes the last byte. The bench drives inputs one time unit after a rising edge and samples one time unit after the next edge, so each check lands on the single cycle where its result is due. It sweeps every byte value in single-buffer mode and all four trigger codes in queued mode, counting the push at which the receive pulse appears. It also runs queue-full drops and clears in both directions.

// File: rtl/uf_pkg.sv
package uf_pkg;

  // Decoded trigger depth for the two-bit code, clamped to the queue capacity
  function automatic int unsigned uf_trig_depth(input logic [1:0] code,
                                                input int unsigned cap);
    int unsigned d;
    case (code)
      2'd0:    d = 1;
      2'd1:    d = 4;
      2'd2:    d = 8;
      default: d = 14;
    endcase
    return (d > cap) ? cap : d;
  endfunction

endpackage

// File: rtl/uf_ctl_reg.sv
module uf_ctl_reg #(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic          en,
  output logic [CW-1:0] trig,
  output logic          clr_rx,
  output logic          clr_tx
);
  import uf_pkg::*;

  logic mode_flip;
  logic unused_bits;

  assign unused_bits = ^wdata[5:3];
  assign mode_flip   = we && (wdata[0] != en);
  // Clear strobes act in the writing cycle only
  assign clr_rx      = we && (wdata[1] || mode_flip);
  assign clr_tx      = we && (wdata[2] || mode_flip);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      trig <= CW'(uf_trig_depth(2'd0, DEPTH));
    end else if (we) begin
      en   <= wdata[0];
      trig <= CW'(uf_trig_depth(wdata[7:6], DEPTH));
    end
  end
endmodule

// File: rtl/uf_byte_fifo.sv
module uf_byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              pushed,
  output logic              popped
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  assign pushed = push && !clr && (count < CW'(DEPTH));
  assign popped = pop && !clr && (count != '0);
  assign head   = mem[rd_ptr];

  // Storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (pushed) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pushed) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
      if (popped) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
      case ({pushed, popped})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uf_rx_path.sv
module uf_rx_path #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CW-1:0]     trig,
  input  logic              clr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              data_ready,
  output logic              overrun,
  output logic              irq_set
);
  logic [DATA_W-1:0] head, hold_q;
  logic [CW-1:0]     count, cnt_next;
  logic              pushed, popped;
  logic              hold_full, hold_full_n;
  logic              ovr_set, irq_n;

  uf_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_q (
    .clk(clk), .rst(rst), .clr(clr),
    .push(en && rx_valid), .pop(en && rd),
    .wdata(rx_data), .head(head), .count(count),
    .pushed(pushed), .popped(popped)
  );

  always_comb begin
    cnt_next = count;
    if (clr) cnt_next = '0;
    else if (pushed && !popped) cnt_next = count + CW'(1);
    else if (popped && !pushed) cnt_next = count - CW'(1);

    hold_full_n = hold_full;
    if (clr) hold_full_n = 1'b0;
    else if (!en) begin
      if (rx_valid)  hold_full_n = 1'b1;
      else if (rd)   hold_full_n = 1'b0;
    end

    ovr_set = !clr && rx_valid &&
              (en ? (count == CW'(DEPTH)) : (hold_full && !rd));
    irq_n   = !clr && rx_valid &&
              (en ? (pushed && !popped && (cnt_next == trig)) : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_full  <= 1'b0;
      rdata      <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
      irq_set    <= 1'b0;
    end else begin
      hold_full  <= hold_full_n;
      data_ready <= hold_full_n || (cnt_next != '0);
      irq_set    <= irq_n;
      if (!clr && !en && rx_valid) hold_q <= rx_data;
      if (!clr && rd) begin
        if (!en)        rdata <= hold_q;
        else if (popped) rdata <= head;
      end
      if (ovr_set)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uf_tx_path.sv
module uf_tx_path #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              thr_empty,
  output logic              irq_set
);
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count, cnt_next;
  logic              pushed, popped;

  uf_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_q (
    .clk(clk), .rst(rst), .clr(clr),
    .push(en && wr), .pop(en && tx_ready),
    .wdata(wdata), .head(head), .count(count),
    .pushed(pushed), .popped(popped)
  );

  always_comb begin
    cnt_next = count;
    if (clr) cnt_next = '0;
    else if (pushed && !popped) cnt_next = count + CW'(1);
    else if (popped && !pushed) cnt_next = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      thr_empty <= 1'b1;
      irq_set   <= 1'b0;
    end else begin
      thr_empty <= (cnt_next == '0);
      if (en) begin
        tx_valid <= popped;
        irq_set  <= popped && (cnt_next == '0);
        if (popped) tx_data <= head;
      end else begin
        tx_valid <= wr && !clr;
        irq_set  <= wr && !clr;
        if (wr && !clr) tx_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ovr_clr,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              thr_empty,
  output logic              rx_irq_set,
  output logic              tx_irq_set
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          fifo_en;
  logic [CW-1:0] trig;
  logic          clr_rx, clr_tx;

  uf_ctl_reg #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .en(fifo_en), .trig(trig), .clr_rx(clr_rx), .clr_tx(clr_tx)
  );

  uf_rx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .en(fifo_en), .trig(trig), .clr(clr_rx),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd(host_rd), .ovr_clr(ovr_clr),
    .rdata(host_rdata), .data_ready(data_ready), .overrun(overrun),
    .irq_set(rx_irq_set)
  );

  uf_tx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .en(fifo_en), .clr(clr_tx),
    .wr(host_wr), .wdata(host_wdata), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .thr_empty(thr_empty),
    .irq_set(tx_irq_set)
  );
endmodule

// File: rtl/uf_fifo_ctrl_chk.sv
module uf_fifo_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_en,
  input logic              rx_valid,
  input logic              host_rd,
  input logic              data_ready,
  input logic              overrun,
  input logic              thr_empty,
  input logic              rx_irq_set,
  input logic              tx_irq_set,
  input logic [DATA_W-1:0] host_rdata
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thr_empty && !data_ready && !overrun && !rx_irq_set && !tx_irq_set));

  // R7
  rx_pulse_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq_set |-> data_ready);

  // R12
  tx_pulse_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq_set |-> thr_empty);

  // R8
  overrun_from_rx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_valid));

  // R11
  tx_pending_only_queued_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_empty |-> fifo_en);

  // R9
  empty_read_holds_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(host_rd) && !$past(data_ready) && $past(fifo_en) && fifo_en) |-> $stable(host_rdata));
endmodule

bind uart_fifo_ctrl uf_fifo_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_valid(rx_valid),
  .host_rd(host_rd), .data_ready(data_ready), .overrun(overrun),
  .thr_empty(thr_empty), .rx_irq_set(rx_irq_set), .tx_irq_set(tx_irq_set),
  .host_rdata(host_rdata)
);

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 0, rx_valid = 0, host_wr = 0, host_rd = 0, ovr_clr = 0, tx_ready = 0;
  logic [7:0] ctl_wdata = 0;
  logic [DATA_W-1:0] rx_data = 0, host_wdata = 0, host_rdata, tx_data;
  logic tx_valid, data_ready, overrun, thr_empty, rx_irq_set, tx_irq_set;

  int n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .ovr_clr(ovr_clr), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .data_ready(data_ready), .overrun(overrun),
    .thr_empty(thr_empty), .rx_irq_set(rx_irq_set), .tx_irq_set(tx_irq_set)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    rx_valid = 1; rx_data = b; cyc(); rx_valid = 0;
  endtask

  task automatic host_read();
    host_rd = 1; cyc(); host_rd = 0;
  endtask

  task automatic host_write(input logic [7:0] b);
    host_wr = 1; host_wdata = b; cyc(); host_wr = 0;
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; cyc(); ctl_we = 0;
  endtask

  task automatic clear_ovr();
    ovr_clr = 1; cyc(); ovr_clr = 0;
  endtask

  function automatic int trig_of(input int code);
    case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 data_ready", data_ready, 0);
    chk("R1 thr_empty", thr_empty, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 host_rdata", host_rdata, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_irq_set", rx_irq_set, 0);

    // R7 and R6: every trigger code in queued mode
    for (int code = 0; code < 4; code++) begin
      ctl_write(8'((code << 6) | 7));
      chk("R2 clear on write", data_ready, 0);
      for (int i = 1; i <= DEPTH; i++) begin
        rx_byte(8'(code * 16 + i));
        chk("R7 trigger pulse", rx_irq_set, (i == trig_of(code)) ? 1 : 0);
        chk("R6 data_ready while held", data_ready, 1);
      end
      for (int i = 1; i <= DEPTH; i++) begin
        host_read();
        chk("R6 order", host_rdata, code * 16 + i);
        chk("R6 data_ready", data_ready, (i < DEPTH) ? 1 : 0);
      end
      host_read();
      chk("R9 empty read", host_rdata, code * 16 + DEPTH);
    end

    // R8 full drop, R10 clear
    ctl_write(8'hC7);
    for (int i = 0; i < DEPTH; i++) rx_byte(8'(8'h30 + i));
    chk("R8 no overrun yet", overrun, 0);
    rx_byte(8'hEE);
    chk("R8 overrun", overrun, 1);
    chk("R8 no pulse", rx_irq_set, 0);
    for (int i = 0; i < DEPTH; i++) begin
      host_read();
      chk("R8 kept bytes", host_rdata, 8'h30 + i);
    end
    chk("R8 dropped byte absent", data_ready, 0);
    clear_ovr();
    chk("R10 overrun cleared", overrun, 0);
    // R10 set wins over clear
    for (int i = 0; i < DEPTH; i++) rx_byte(8'(i));
    rx_valid = 1; rx_data = 8'hEF; ovr_clr = 1; cyc(); rx_valid = 0; ovr_clr = 0;
    chk("R10 set wins", overrun, 1);
    clear_ovr();

    // R2 receive clear acts once
    ctl_write(8'hC3);
    chk("R2 rx cleared", data_ready, 0);
    host_read();
    chk("R9 read after clear", host_rdata, 8'h3D);
    rx_byte(8'h55);
    chk("R2 clear not stored", data_ready, 1);
    host_read();
    chk("R2 byte after clear", host_rdata, 8'h55);

    // Single-buffer mode: R3 sweep over all byte values
    ctl_write(8'h00);
    for (int v = 0; v < 256; v++) begin
      rx_byte(8'(v));
      chk("R3 data_ready set", data_ready, 1);
      chk("R3 rx pulse", rx_irq_set, 1);
      host_read();
      chk("R3 read value", host_rdata, v);
      chk("R3 data_ready cleared", data_ready, 0);
    end
    // R4 overrun in single-buffer mode
    rx_byte(8'h11);
    rx_byte(8'h22);
    chk("R4 overrun", overrun, 1);
    host_read();
    chk("R4 newest kept", host_rdata, 8'h22);
    clear_ovr();
    chk("R10 cleared", overrun, 0);

    // R5 single-buffer transmit sweep
    tx_ready = 0;
    for (int v = 0; v < 256; v++) begin
      host_write(8'(v));
      chk("R5 tx_valid", tx_valid, 1);
      chk("R5 tx_data", tx_data, v);
      chk("R5 tx pulse", tx_irq_set, 1);
      chk("R5 thr_empty", thr_empty, 1);
    end
    cyc();
    chk("R5 tx_valid idle", tx_valid, 0);

    // R11/R12 queued transmit
    ctl_write(8'h07);
    chk("R12 empty after enable", thr_empty, 1);
    for (int i = 0; i < 5; i++) begin
      host_write(8'(8'hA0 + i));
      chk("R11 thr_empty low", thr_empty, 0);
      chk("R11 held", tx_valid, 0);
    end
    tx_ready = 1;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk("R11 tx_valid", tx_valid, 1);
      chk("R11 tx order", tx_data, 8'hA0 + k);
      chk("R12 thr_empty on drain", thr_empty, (k == 4) ? 1 : 0);
      chk("R12 tx pulse on drain", tx_irq_set, (k == 4) ? 1 : 0);
    end
    cyc();
    chk("R11 drained", tx_valid, 0);
    chk("R12 single pulse", tx_irq_set, 0);

    // R11 transmit queue full drop
    tx_ready = 0;
    for (int i = 0; i < DEPTH + 2; i++) host_write(8'(i));
    tx_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      cyc();
      chk("R11 full drain", tx_data, i);
    end
    cyc();
    chk("R11 extra dropped", tx_valid, 0);

    // R12 transmit clear: empty without pulse
    tx_ready = 0;
    for (int i = 0; i < 3; i++) host_write(8'(i));
    ctl_write(8'h05);
    chk("R12 clear sets empty", thr_empty, 1);
    chk("R12 clear no pulse", tx_irq_set, 0);
    tx_ready = 1;
    cyc();
    chk("R2 tx cleared", tx_valid, 0);
    tx_ready = 0;

    // R1 reset in queued mode returns to single-buffer
    rx_byte(8'h01);
    rx_byte(8'h02);
    rst = 1; cyc(); cyc(); rst = 0;
    cyc();
    chk("R1 rx emptied", data_ready, 0);
    rx_byte(8'h77);
    rx_byte(8'h78);
    chk("R1 single-buffer after reset", overrun, 1);
    host_read();
    chk("R1 holding byte", host_rdata, 8'h78);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule